// File: doc/BRIEF.md
# Reference-Resynchronised Accumulator Oscillator with Successive-Approximation Tuning

This block makes a digital clock whose most significant phase bit toggles at a frequency set by an increment word. A phase register adds the increment on every system clock and wraps at the width of the accumulator. The top bit of the register is the oscillator output. A single-bit reference input passes through a two-flop synchroniser. Each falling edge of the reference makes a sync pulse one system clock wide. The sync pulse clears the phase register, so the phase error can never build up past one reference period.

Between two sync pulses, a meter counts the rising edges of the output. At the sync instant it judges whether the output leads or lags the wanted count of P periods per reference period. It also folds the phase left in the register into an error magnitude, and only the upper ERR_BITS bits of that magnitude are kept. A successive-approximation search uses the lead/lag verdict to settle one bit of the increment on each reference cycle, starting at the top bit. When the search has finished, a lock flag reports whether the error lies inside the bound of 2^-ERR_BITS output periods.

Top module: `jitter_dco_loop`

## Requirements
- R1: On every system clock without a sync pulse, the phase register becomes (phase + k) modulo 2^ACC_W. `dco_out` is the register's top bit, so over a reference period of R system clocks the output completes (R-1)·k/2^ACC_W periods, counted with rising edges at half-phase crossings.
- R2: The reference goes through two synchronising flops. A falling edge of the synchronised reference produces a sync pulse exactly one clock wide. The sync pulse loads zero into the phase register, so `dco_out` is low in the cycle that follows.
- R3: `k_word` changes only on the clock edge that ends a sync cycle. It stays constant between sync pulses.
- R4: At each sync the meter counts rising edges of `dco_out` since the previous sync, including one in the sync cycle itself. The output is judged to lead if that count exceeds P, or if it equals P and the top phase bit is 0. Otherwise it lags.
- R5: After reset, `k_word` is 2^(ACC_W-1) and the bit under test is the top bit. The first sync after reset only starts a measurement. At each later sync, until the search is done: the bit under test is cleared if the output leads and kept if it lags. The next lower bit is then set and becomes the bit under test. The sync that decides bit 0 ends the search.
- R6: With a reference period of R clocks, the final `k_word` is the largest k for which (R-1)·k < P·2^ACC_W.
- R7: The phase error magnitude is the phase value at sync, taken as distance to the nearest whole period (two's-complement negated when the top bit is 1). `locked` stays 0 until the search is done. At each sync after that, it is set to 1 when the count equals P and the top ERR_BITS bits of the error magnitude are zero, and to 0 otherwise.
- R8: Once the search has finished, `dco_out` shows exactly P rising edges between consecutive reference falling edges whenever (R-1)·k lies in [(P-1/2)·2^ACC_W, (P+1/2)·2^ACC_W).
- R9: During reset, `dco_out` and `locked` are 0 and `k_word` equals 2^(ACC_W-1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_in | input | 1 | Reference clock, asynchronous to clk |
| dco_out | output | 1 | Oscillator output, the phase register's top bit |
| k_word | output | ACC_W | Current increment word |
| locked | output | 1 | Search done and phase error inside the jitter bound |

## Verification
The hardest case to reach from the ports is a finished search whose residual error lies outside the jitter bound: the count equals P, but the folded phase error is too large. This happens only when the reference period is long compared with the accumulator resolution. The bench reaches it with a reference period of 1500 clocks on a 12-bit accumulator with ERR_BITS of 3, where the final increment leaves about a third of a period of error. Shorter periods, whose lock is expected, are run alongside it. Each trial value of k is predicted from the closed-form lead condition (R-1)·k ≥ P·2^ACC_W and compared as the design changes it.

// File: rtl/jdl_pkg.sv
package jdl_pkg;
  // Lead verdict: too many output periods, or exactly P with phase past the wrap point.
  function automatic logic is_leading(input int unsigned edges,
                                      input int unsigned target,
                                      input logic        top_bit);
    return (edges > target) || ((edges == target) && !top_bit);
  endfunction
endpackage

// File: rtl/jdl_ref_sync.sv
module jdl_ref_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic sync_pulse
);
  // [0],[1] synchroniser, [2] edge history
  logic [2:0] ref_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_sh <= '0;
    else        ref_sh <= {ref_sh[1:0], ref_in};
  end

  assign sync_pulse = ref_sh[2] & ~ref_sh[1];
endmodule

// File: rtl/jdl_phase_acc.sv
module jdl_phase_acc #(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_pulse,
  input  logic [ACC_W-1:0] k_word,
  output logic [ACC_W-1:0] phase,
  output logic             msb_rise
);
  logic msb_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase <= '0;
      msb_q <= 1'b0;
    end else begin
      phase <= sync_pulse ? '0 : (phase + k_word);
      msb_q <= phase[ACC_W-1];
    end
  end

  assign msb_rise = phase[ACC_W-1] & ~msb_q;
endmodule

// File: rtl/jdl_period_meter.sv
module jdl_period_meter #(
  parameter int ACC_W      = 28,
  parameter int ERR_BITS   = 12,
  parameter int TARGET_P   = 8,
  parameter int EDGE_CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_pulse,
  input  logic             msb_rise,
  input  logic [ACC_W-1:0] phase,
  output logic             meas_lead,
  output logic             meas_on_target
);
  localparam logic [EDGE_CNT_W-1:0] P_CNT = EDGE_CNT_W'(TARGET_P);

  function automatic logic [ACC_W-1:0] fold_err(input logic [ACC_W-1:0] ph);
    return ph[ACC_W-1] ? (~ph + 1'b1) : ph;
  endfunction

  logic [EDGE_CNT_W-1:0] edge_cnt, edges_now;
  logic [ACC_W-1:0]      err_mag;
  logic [ERR_BITS-1:0]   err_slice;

  assign edges_now = (edge_cnt == '1) ? edge_cnt : (edge_cnt + EDGE_CNT_W'(msb_rise));

  always_ff @(posedge clk) begin
    if (!rst_n)          edge_cnt <= '0;
    else if (sync_pulse) edge_cnt <= '0;
    else                 edge_cnt <= edges_now;
  end

  assign err_mag        = fold_err(phase);
  assign err_slice      = err_mag[ACC_W-1 -: ERR_BITS];
  assign meas_lead      = jdl_pkg::is_leading(32'(edges_now), 32'(TARGET_P), phase[ACC_W-1]);
  assign meas_on_target = (edges_now == P_CNT) && (err_slice == '0);
endmodule

// File: rtl/jdl_sar.sv
module jdl_sar #(
  parameter int ACC_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync_pulse,
  input  logic             meas_lead,
  input  logic             meas_on_target,
  output logic [ACC_W-1:0] k_word,
  output logic             primed,
  output logic             search_done,
  output logic             locked
);
  localparam int IDX_W = (ACC_W > 1) ? $clog2(ACC_W) : 1;
  localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(ACC_W - 1);
  localparam logic [ACC_W-1:0] K_RESET = {1'b1, {(ACC_W-1){1'b0}}};

  logic [IDX_W-1:0] bit_idx;
  logic [ACC_W-1:0] k_next;

  always_comb begin
    k_next = k_word;
    if (meas_lead) k_next[bit_idx] = 1'b0;
    if (bit_idx != '0) k_next[bit_idx - 1'b1] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      k_word      <= K_RESET;
      bit_idx     <= TOP_IDX;
      primed      <= 1'b0;
      search_done <= 1'b0;
      locked      <= 1'b0;
    end else if (sync_pulse) begin
      if (!primed) begin
        primed <= 1'b1;
      end else if (!search_done) begin
        k_word <= k_next;
        if (bit_idx == '0) search_done <= 1'b1;
        else               bit_idx     <= bit_idx - 1'b1;
      end else begin
        locked <= meas_on_target;
      end
    end
  end
endmodule

// File: rtl/jitter_dco_loop.sv
module jitter_dco_loop #(
  parameter int ACC_W      = 28,
  parameter int ERR_BITS   = 12,
  parameter int TARGET_P   = 8,
  parameter int EDGE_CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ref_in,
  output logic             dco_out,
  output logic [ACC_W-1:0] k_word,
  output logic             locked
);
  logic             sync_pulse;
  logic [ACC_W-1:0] phase;
  logic             msb_rise;
  logic             meas_lead;
  logic             meas_on_target;
  logic             primed;
  logic             search_done;

  jdl_ref_sync u_sync (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .sync_pulse(sync_pulse)
  );

  jdl_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .k_word(k_word),
    .phase(phase), .msb_rise(msb_rise)
  );

  jdl_period_meter #(
    .ACC_W(ACC_W), .ERR_BITS(ERR_BITS), .TARGET_P(TARGET_P), .EDGE_CNT_W(EDGE_CNT_W)
  ) u_meter (
    .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .msb_rise(msb_rise),
    .phase(phase), .meas_lead(meas_lead), .meas_on_target(meas_on_target)
  );

  jdl_sar #(.ACC_W(ACC_W)) u_sar (
    .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .meas_lead(meas_lead),
    .meas_on_target(meas_on_target), .k_word(k_word), .primed(primed),
    .search_done(search_done), .locked(locked)
  );

  assign dco_out = phase[ACC_W-1];
endmodule

// File: rtl/jdl_checker.sv
module jdl_checker #(
  parameter int ACC_W = 28
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_pulse,
  input logic [ACC_W-1:0] phase,
  input logic [ACC_W-1:0] k_word,
  input logic             primed,
  input logic             search_done,
  input logic             locked
);
  p_accumulate_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_pulse |=> phase == ACC_W'($past(phase) + $past(k_word)));

  p_clear_on_sync_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> phase == '0);

  p_sync_narrow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sync_pulse |=> !sync_pulse);

  p_k_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_pulse |=> $stable(k_word));

  p_one_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_pulse && primed && !search_done) |=> $countones(k_word ^ $past(k_word)) <= 2);

  p_lock_after_search_r7: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> search_done);
endmodule

bind jitter_dco_loop jdl_checker #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sync_pulse(sync_pulse), .phase(phase),
  .k_word(k_word), .primed(primed), .search_done(search_done), .locked(locked)
);

// File: tb/jitter_dco_loop_bench.sv
module jitter_dco_loop_bench;
  localparam int CLK_PERIOD = 10;
  localparam int N   = 12;
  localparam int EB  = 3;
  localparam int P   = 4;
  localparam int WATCHDOG = 190000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_in = 1'b1;
  logic dco_out;
  logic [N-1:0] k_word;
  logic locked;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [N-1:0] exp_k [$];
  logic [N-1:0] last_k;

  jitter_dco_loop #(.ACC_W(N), .ERR_BITS(EB), .TARGET_P(P), .EDGE_CNT_W(16)) u_jitter_dco_loop (
    .clk(clk), .rst_n(rst_n), .ref_in(ref_in),
    .dco_out(dco_out), .k_word(k_word), .locked(locked)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Monitor: each change of k_word must match the next predicted trial value.
  always @(negedge clk) begin
    cycles++;
    if (!rst_n) last_k = k_word;
    else if (k_word != last_k) begin
      if (exp_k.size() == 0) check(1'b0, "R5 unexpected k change", k_word, last_k);
      else begin
        logic [N-1:0] e;
        e = exp_k.pop_front();
        check(k_word == e, "R5 trial k", k_word, e);
      end
      last_k = k_word;
    end
    if (cycles > WATCHDOG) begin
      check(1'b0, "watchdog", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit leads(input longint r, input longint k);
    return (r - 1) * k >= longint'(P) * (longint'(1) << N);
  endfunction

  // Driver: predict the search and push the trial sequence, then run the reference.
  task automatic run_case(input int r);
    logic [N-1:0] kt, kn;
    longint kf, phi, err, half, full;
    bit exp_lock;
    int rises, last_rises, prev;
    rst_n = 1'b0; ref_in = 1'b1;
    repeat (4) @(negedge clk);
    check(dco_out == 1'b0, "R9 dco in reset", dco_out, 0);
    check(locked == 1'b0, "R9 lock in reset", locked, 0);
    check(k_word == (1 << (N-1)), "R9 k in reset", k_word, 1 << (N-1));
    exp_k.delete();
    kt = 1 << (N-1);
    for (int b = N-1; b >= 0; b--) begin
      kn = kt;
      if (leads(r, kt)) kn[b] = 1'b0;
      if (b > 0) kn[b-1] = 1'b1;
      if (kn != kt) exp_k.push_back(kn);
      kt = kn;
    end
    kf = kt;
    full = longint'(1) << N;
    half = full / 2;
    phi = (r - 1) * kf;
    err = longint'(P) * full - phi;
    exp_lock = (phi >= longint'(P) * full - half) && (err < (full >> EB));
    rst_n = 1'b1;
    rises = 0; last_rises = -1; prev = 0;
    for (int c = 0; c < (N + 5) * r; c++) begin
      @(negedge clk);
      if (dco_out && !prev) rises++;
      prev = dco_out;
      ref_in = ((c % r) < (r / 2));
      if ((c % r) == r / 2) begin
        last_rises = rises;
        rises = 0;
      end
      if ((c % r) == r / 2 + 3 && c > r) check(dco_out == 1'b0, "R2 phase cleared after sync", dco_out, 0);
      if (c == 6 * r) check(locked == 1'b0, "R7 no lock during search", locked, 0);
    end
    check(exp_k.size() == 0, "R5 all trials seen", exp_k.size(), 0);
    check(k_word == kf, "R6 R4 final k", k_word, kf);
    check(locked == exp_lock, "R7 lock verdict", locked, exp_lock);
    check(last_rises == P, "R8 R1 rises per reference period", last_rises, P);
  endtask

  initial begin
    run_case(256);
    run_case(200);
    run_case(1000);
    run_case(1500);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule